// File: doc/BRIEF.md
# Two-Level Interrupt Request Aggregator

This block gathers interrupt conditions for a small processor core and reduces them to a single request line. It recognises three kinds of core event. The first is a timer rollover pulse. The second is a chosen edge on an external interrupt pin. The third is a level change on any of six general-purpose pins that software has armed. It also latches up to seven peripheral event pulses into a separate flag register, which has its own enable register.

Each condition sets a sticky flag whether or not its enable bits are set. Software clears a flag by writing 0 to it. If the hardware sets a flag in the same cycle as a software clear, the set wins.

The request line is gated in two levels. A core source needs its own enable and the global enable. A peripheral source also needs the shared peripheral enable. The pin-change detector compares the synchronized pins against a snapshot, and the snapshot is refreshed each time software reads the pin port.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, every register (core control at address 0, peripheral flags at 1, peripheral enables at 2, pin arm mask at 3) reads 0x00 and `irq` is 0.
- R2: The core control register at address 0 holds, from bit 7 down to bit 0: global enable, peripheral enable, timer enable, external-pin enable, pin-change enable, timer flag, external-pin flag, pin-change flag. A write to it stores the five enable bits exactly as written.
- R3: A timer event pulse sets the timer flag (bit 2) on the next clock edge, even when every enable bit is 0.
- R4: A flag stays at 1 until a register write puts 0 in its bit position. Writing 1 to a flag bit sets it.
- R5: When a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends at 1.
- R6: The peripheral flag register (address 1) and enable register (address 2) always read bit 4 as 0. A peripheral event pulse on bit i (i not 4) sets flag bit i, and an event on bit 4 has no effect.
- R7: When `ext_rise_sel` is 1, a rising edge on `ext_pin` sets the external-pin flag (bit 1). When it is 0, a falling edge sets that flag instead. The edge of the other direction does not set it. The flag rises on the third clock edge after the pin changes.
- R8: Reading address 4 returns the synchronized pins in bits 5:0 and loads them as the snapshot. The pin-change flag (bit 0) sets while any pin armed in the mask at address 3 differs from the snapshot. A change on an unarmed pin does not set it.
- R9: `irq` is 1 only when the global enable is set and either a core flag is 1 together with its own enable, or a peripheral request (R10) is present.
- R10: A peripheral flag that is set together with its enable raises `irq` only when the peripheral enable bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select (0 core, 1 peripheral flags, 2 peripheral enables, 3 arm mask, 4 pin port) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 4 refreshes the pin snapshot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tmr_ovf_evt | input | 1 | Timer rollover pulse |
| periph_evt | input | 8 | Peripheral event pulses, bit 4 unused |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel | input | 1 | 1 selects a rising edge, 0 selects a falling edge |
| gpio_pins | input | 6 | General-purpose pins, asynchronous |
| irq | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that `ext_rise_sel` only changes while the synchronized external pin is steady. They also assume that `reg_rd` is low while reset is applied, so the pin snapshot never starts from a read that happened inside reset. The stimulus respects both assumptions. It changes the edge select only after the pin has been stable for at least four cycles, and it issues reads only after reset is released. Pin and event changes are applied between clock edges, so a behavioural model can follow them cycle by cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int PIN_N   = 6;
    localparam int PER_N   = 8;
    localparam int HOLE_IX = 4;

    localparam logic [PER_N-1:0] PER_MASK = ~(PER_N'(1) << HOLE_IX);

    typedef enum logic [ADDR_W-1:0] {
        SEL_CORE  = 3'd0,
        SEL_PFLAG = 3'd1,
        SEL_PEN   = 3'd2,
        SEL_ARM   = 3'd3,
        SEL_PORT  = 3'd4
    } reg_sel_e;

    // bit order is software-visible: msb first
    typedef struct packed {
        logic gie;
        logic peie;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_flag;
        logic ext_flag;
        logic chg_flag;
    } core_t;

    function automatic logic any_armed(input logic [PER_N-1:0] en,
                                       input logic [PER_N-1:0] fl);
        return |(en & fl);
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/intc_pin_events.sv
module intc_pin_events #(
    parameter int NPIN = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pins_s,
    input  logic            ext_s,
    input  logic            edge_rising,
    input  logic [NPIN-1:0] arm,
    input  logic            snap_load,
    output logic            ext_hit,
    output logic            chg_hit
);
    logic            ext_prev;
    logic [NPIN-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= 1'b0;
            snap     <= '0;
        end else begin
            ext_prev <= ext_s;
            if (snap_load) snap <= pins_s;
        end
    end

    always_comb begin
        if (edge_rising) ext_hit = ext_s & ~ext_prev;
        else             ext_hit = ~ext_s & ext_prev;
        chg_hit = |((pins_s ^ snap) & arm);
    end

    // R7: a detected edge always leaves the pin at the selected level
    p_ext_dir_r7: assert property (@(posedge clk) disable iff (rst)
        ext_hit |-> (edge_rising ? ext_s : !ext_s));

    // R8: right after a snapshot with steady pins no change is seen
    p_snap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(snap_load) && $stable(pins_s)) |-> !chg_hit);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tmr_set,
    input  logic              ext_set,
    input  logic              chg_set,
    input  logic [PER_N-1:0]  per_set,
    input  logic [PIN_N-1:0]  port_val,
    output core_t             core,
    output logic [PER_N-1:0]  pflag,
    output logic [PER_N-1:0]  pen,
    output logic [PIN_N-1:0]  arm
);
    logic wr_core, wr_pf, wr_pe, wr_arm;
    core_t wcore;

    always_comb begin
        wr_core = wr && (addr == SEL_CORE);
        wr_pf   = wr && (addr == SEL_PFLAG);
        wr_pe   = wr && (addr == SEL_PEN);
        wr_arm  = wr && (addr == SEL_ARM);
        wcore   = core_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core  <= '0;
            pflag <= '0;
            pen   <= '0;
            arm   <= '0;
        end else begin
            if (wr_core) begin
                core.gie    <= wcore.gie;
                core.peie   <= wcore.peie;
                core.tmr_en <= wcore.tmr_en;
                core.ext_en <= wcore.ext_en;
                core.chg_en <= wcore.chg_en;
            end
            // hardware set dominates a simultaneous software clear
            core.tmr_flag <= tmr_set | (wr_core ? wcore.tmr_flag : core.tmr_flag);
            core.ext_flag <= ext_set | (wr_core ? wcore.ext_flag : core.ext_flag);
            core.chg_flag <= chg_set | (wr_core ? wcore.chg_flag : core.chg_flag);
            pflag <= (per_set | (wr_pf ? wdata : pflag)) & PER_MASK;
            if (wr_pe)  pen <= wdata & PER_MASK;
            if (wr_arm) arm <= wdata[PIN_N-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            SEL_CORE:  rdata = core;
            SEL_PFLAG: rdata = pflag;
            SEL_PEN:   rdata = pen;
            SEL_ARM:   rdata = {{(DATA_W-PIN_N){1'b0}}, arm};
            SEL_PORT:  rdata = {{(DATA_W-PIN_N){1'b0}}, port_val};
            default:   rdata = '0;
        endcase
    end

    // R4: a timer flag only drops after a write of 0 to its bit
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(core.tmr_flag) |-> $past(wr_core && !wdata[2]));

    // R5: a hardware set is always visible on the following cycle
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (tmr_set || ext_set || chg_set) |=>
            ((core.tmr_flag || !$past(tmr_set)) &&
             (core.ext_flag || !$past(ext_set)) &&
             (core.chg_flag || !$past(chg_set))));

    // R6: implemented peripheral events always land in the flag register
    p_per_set_r6: assert property (@(posedge clk) disable iff (rst)
        |(per_set & PER_MASK) |=>
            ((pflag & $past(per_set & PER_MASK)) == $past(per_set & PER_MASK)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 tmr_ovf_evt,
    input  logic [PER_N-1:0]     periph_evt,
    input  logic                 ext_pin,
    input  logic                 ext_rise_sel,
    input  logic [PIN_N-1:0]     gpio_pins,
    output logic                 irq
);
    localparam int SYNC_W = PIN_N + 1;

    logic [SYNC_W-1:0] sync_q;
    logic [PIN_N-1:0]  pins_s;
    logic              ext_s;
    logic              ext_hit, chg_hit, snap_load;
    logic              core_req, per_req;
    core_t             core;
    logic [PER_N-1:0]  pflag, pen;
    logic [PIN_N-1:0]  arm;

    intc_sync #(.W(SYNC_W), .STAGES(2)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ext_pin, gpio_pins}),
        .dout (sync_q)
    );

    assign pins_s    = sync_q[PIN_N-1:0];
    assign ext_s     = sync_q[PIN_N];
    assign snap_load = reg_rd && (reg_addr == SEL_PORT);

    intc_pin_events #(.NPIN(PIN_N)) i_pins (
        .clk         (clk),
        .rst         (rst),
        .pins_s      (pins_s),
        .ext_s       (ext_s),
        .edge_rising (ext_rise_sel),
        .arm         (arm),
        .snap_load   (snap_load),
        .ext_hit     (ext_hit),
        .chg_hit     (chg_hit)
    );

    intc_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .tmr_set  (tmr_ovf_evt),
        .ext_set  (ext_hit),
        .chg_set  (chg_hit),
        .per_set  (periph_evt),
        .port_val (pins_s),
        .core     (core),
        .pflag    (pflag),
        .pen      (pen),
        .arm      (arm)
    );

    always_comb begin
        core_req = (core.tmr_en & core.tmr_flag) |
                   (core.ext_en & core.ext_flag) |
                   (core.chg_en & core.chg_flag);
        per_req  = core.peie & any_armed(pen, pflag);
        irq      = core.gie & (core_req | per_req);
    end

    // R9: no request ever leaves without the global enable
    p_gie_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> core.gie);

    // R10: a request with no core source behind it needs the peripheral enable
    p_peie_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !(core.tmr_en && core.tmr_flag) && !(core.ext_en && core.ext_flag)
             && !(core.chg_en && core.chg_flag)) |-> core.peie);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tmr_ovf_evt = 1'b0;
    logic [7:0] periph_evt = '0;
    logic       ext_pin = 1'b0, ext_rise_sel = 1'b1;
    logic [5:0] gpio_pins = '0;
    logic       irq;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmr_ovf_evt(tmr_ovf_evt), .periph_evt(periph_evt), .ext_pin(ext_pin),
        .ext_rise_sel(ext_rise_sel), .gpio_pins(gpio_pins), .irq(irq)
    );

    // behavioural reference
    bit [7:0] m_core, m_pir, m_pie;
    bit [5:0] m_arm, m_snap, g1, g2;
    bit       e1, e2, eprev;

    always @(posedge clk) begin : model
        bit eh, ch;
        bit [7:0] nc, np;
        if (rst) begin
            m_core = 0; m_pir = 0; m_pie = 0; m_arm = 0; m_snap = 0;
            g1 = 0; g2 = 0; e1 = 0; e2 = 0; eprev = 0;
        end else begin
            eh = ext_rise_sel ? (e2 && !eprev) : (!e2 && eprev);
            ch = |((g2 ^ m_snap) & m_arm);
            nc = (reg_wr && reg_addr == 0) ? reg_wdata : m_core;
            nc[2] = nc[2] | tmr_ovf_evt;
            nc[1] = nc[1] | eh;
            nc[0] = nc[0] | ch;
            np = (reg_wr && reg_addr == 1) ? reg_wdata : m_pir;
            np = np | periph_evt;
            np[4] = 1'b0;
            if (reg_wr && reg_addr == 2) begin m_pie = reg_wdata; m_pie[4] = 1'b0; end
            if (reg_wr && reg_addr == 3) m_arm = reg_wdata[5:0];
            if (reg_rd && reg_addr == 4) m_snap = g2;
            m_core = nc; m_pir = np;
            eprev = e2; e2 = e1; e1 = ext_pin; g2 = g1; g1 = gpio_pins;
        end
    end

    function automatic bit [7:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return m_core;
            3'd1: return m_pir;
            3'd2: return m_pie;
            3'd3: return {2'b00, m_arm};
            3'd4: return {2'b00, g2};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_irq();
        return m_core[7] && ((|(m_core[5:3] & m_core[2:0])) ||
                             (m_core[6] && |(m_pie & m_pir)));
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: compare outputs with the model away from the active edge
    task automatic tick();
        @(negedge clk);
        check({7'd0, irq}, {7'd0, m_irq()}, cur_req, "per-cycle irq");
        check(reg_rdata, m_read(reg_addr), cur_req, "per-cycle rdata");
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit [2:0] a, input bit [7:0] exp, input string req);
        reg_addr = a; reg_rd = 1'b1;
        #1 check(reg_rdata, exp, req, $sformatf("read addr %0d", a));
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        waitn(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        cur_req = "R1";
        check({7'd0, irq}, 8'd0, "R1", "irq after reset");
        for (int a = 0; a < 4; a++) rd(3'(a), 8'h00, "R1");
        // R2 enable bits
        cur_req = "R2";
        wr(0, 8'hF8);
        rd(0, 8'hF8, "R2");
        check({7'd0, irq}, 8'd0, "R2", "irq with enables only");
        wr(0, 8'h00);
        // R3 flag sets with all enables off
        cur_req = "R3";
        tmr_ovf_evt = 1'b1; tick(); tmr_ovf_evt = 1'b0;
        rd(0, 8'h04, "R3");
        check({7'd0, irq}, 8'd0, "R3", "irq with flag only");
        // R4 sticky, cleared by writing 0, set by writing 1
        cur_req = "R4";
        waitn(5);
        rd(0, 8'h04, "R4");
        wr(0, 8'h00);
        rd(0, 8'h00, "R4");
        wr(0, 8'h02);
        rd(0, 8'h02, "R4");
        wr(0, 8'h00);
        // R5 set beats clear
        cur_req = "R5";
        wr(0, 8'h04);
        reg_addr = 0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf_evt = 1'b1;
        tick();
        reg_wr = 1'b0; tmr_ovf_evt = 1'b0;
        rd(0, 8'h04, "R5");
        wr(0, 8'h00);
        // R6 peripheral registers and the unused bit
        cur_req = "R6";
        wr(2, 8'hFF);
        rd(2, 8'hEF, "R6");
        periph_evt = 8'hFF; tick(); periph_evt = 8'h00;
        rd(1, 8'hEF, "R6");
        wr(1, 8'h00);
        periph_evt = 8'h10; tick(); periph_evt = 8'h00;
        rd(1, 8'h00, "R6");
        // R10 peripheral gate
        cur_req = "R10";
        wr(2, 8'h01);
        periph_evt = 8'h01; tick(); periph_evt = 8'h00;
        wr(0, 8'h80);
        check({7'd0, irq}, 8'd0, "R10", "irq without peripheral enable");
        wr(0, 8'hC0);
        check({7'd0, irq}, 8'd1, "R10", "irq with peripheral enable");
        wr(1, 8'h00);
        check({7'd0, irq}, 8'd0, "R10", "irq after peripheral clear");
        wr(0, 8'h00);
        // R9 core gating
        cur_req = "R9";
        wr(0, 8'hA0);
        tmr_ovf_evt = 1'b1; tick(); tmr_ovf_evt = 1'b0;
        check({7'd0, irq}, 8'd1, "R9", "irq timer enabled");
        wr(0, 8'h24);
        check({7'd0, irq}, 8'd0, "R9", "irq global off");
        wr(0, 8'h00);
        // R7 edge select
        cur_req = "R7";
        ext_rise_sel = 1'b1;
        ext_pin = 1'b1; waitn(2);
        rd(0, 8'h00, "R7");       // not yet: third edge not reached
        waitn(1);
        rd(0, 8'h02, "R7");
        wr(0, 8'h00);
        ext_pin = 1'b0; waitn(4);
        rd(0, 8'h00, "R7");
        ext_rise_sel = 1'b0;
        ext_pin = 1'b1; waitn(4);
        rd(0, 8'h00, "R7");
        ext_pin = 1'b0; waitn(4);
        rd(0, 8'h02, "R7");
        wr(0, 8'h00);
        // R8 pin change with arm mask and snapshot
        cur_req = "R8";
        wr(3, 8'h01);
        rd(3, 8'h01, "R8");
        gpio_pins = 6'h02; waitn(4);
        rd(0, 8'h00, "R8");
        gpio_pins = 6'h03; waitn(4);
        rd(0, 8'h01, "R8");
        rd(4, 8'h03, "R8");
        wr(0, 8'h00);
        waitn(2);
        rd(0, 8'h00, "R8");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule